// File: doc/BRIEF.md
# Carry-Function Prefix Adder

This block adds two unsigned operands of a parameterized width together with a single carry-in bit. It produces the sum word and the carry-out in the same cycle, with no storage on the path. It does not ripple a carry from bit to bit. Instead, each bit position is described by what it does to the carry that reaches it: it may force the carry to one, pass the carry through unchanged, or force it to zero. These per-position descriptions are two-bit codes. They are merged in a logarithmic tree, so every carry is known after a small, fixed number of merge levels.

The carry-in takes part as one more code, placed below the least significant bit. Because of this, every merged span that reaches down to the bottom of the word ends up as either "force one" or "force zero", and that value is the carry into the next position. Each sum bit is the pass-through indicator of its position XORed with the carry that enters it.

The block is meant to serve as a wide, fast adder inside a larger datapath. The surrounding logic registers its inputs and outputs as needed.

Top module: `gps_prefix_adder`

## Requirements
- R1: Each operand bit pair is classed as force-one (code 2'b10) when both bits are 1, pass (code 2'b01) when exactly one bit is 1, and force-zero (code 2'b00) when both bits are 0.
- R2: Merging a lower-significance code with the next higher one gives the higher code when that code is force-one or force-zero, and gives the lower code when the higher code is pass.
- R3: The carry-in acts as a code below bit 0: force-one when cin_i is 1 and force-zero when it is 0. When every position is pass, the carry-out equals cin_i and every sum bit equals the inverse of cin_i.
- R4: Every merged span that reaches the carry-in position resolves to force-one or force-zero and never to pass.
- R5: sum_o equals (a_i + b_i + cin_i) modulo 2 to the power WIDTH, with each sum bit formed as that position's pass indicator XOR the carry entering it.
- R6: cout_o equals bit WIDTH of a_i + b_i + cin_i.
- R7: A force-one position followed by an unbroken run of pass positions up to the top bit drives cout_o to 1. A force-zero position inside such a run stops it, so cout_o is 0 whatever lies below that position.
- R8: The outputs depend only on the present inputs. A new operand pair is reflected at sum_o and cout_o in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First addend |
| b_i | input | WIDTH | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum word |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Every result of this adder is due zero cycles after its stimulus. The sum and carry-out settle within the same clock period in which the operands change. The driver applies each operand pair just after a rising edge and queues the expected sum and carry-out. The monitor pops one entry at the following falling edge and compares it against the outputs, so each result is sampled half a period after its stimulus and before the next pair is applied.

// File: rtl/gps_adder_pkg.sv
package gps_adder_pkg;

  typedef enum logic [1:0] {
    CODE_SQUASH = 2'b00,
    CODE_PROP   = 2'b01,
    CODE_GEN    = 2'b10
  } gps_code_t;

  // Merge a lower-significance span with the adjacent higher one (R2).
  function automatic gps_code_t gps_compose(input gps_code_t lo, input gps_code_t hi);
    gps_code_t res;
    if (hi == CODE_PROP) res = lo;
    else                 res = hi;
    return res;
  endfunction

endpackage

// File: rtl/gps_bit_classify.sv
module gps_bit_classify
  import gps_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]     a_i,
  input  logic [WIDTH-1:0]     b_i,
  input  logic                 cin_i,
  output logic [WIDTH:0][1:0]  leaf_o,
  output logic [WIDTH-1:0]     prop_o
);

  // Slot 0 holds the carry-in as a resolved code (R3).
  always_comb begin
    if (cin_i) leaf_o[0] = CODE_GEN;
    else       leaf_o[0] = CODE_SQUASH;
  end

  // One code per operand position (R1).
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      prop_o[i] = a_i[i] ^ b_i[i];
      if (a_i[i] & b_i[i])        leaf_o[i+1] = CODE_GEN;
      else if (a_i[i] ^ b_i[i])   leaf_o[i+1] = CODE_PROP;
      else                        leaf_o[i+1] = CODE_SQUASH;
    end
  end

endmodule

// File: rtl/gps_prefix_tree.sv
module gps_prefix_tree
  import gps_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH:0][1:0] leaf_i,
  output logic [WIDTH:0][1:0] span_o
);

  localparam int NODES  = WIDTH + 1;
  localparam int LEVELS = (NODES > 1) ? $clog2(NODES) : 1;

  logic [LEVELS:0][WIDTH:0][1:0] node;

  assign node[0] = leaf_i;

  // Each level doubles the span every node covers, reaching down to slot 0.
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int DIST = 1 << l;
    for (genvar j = 0; j < NODES; j++) begin : g_node
      if (j >= DIST) begin : g_merge
        assign node[l+1][j] = gps_compose(gps_code_t'(node[l][j-DIST]),
                                          gps_code_t'(node[l][j]));
      end else begin : g_pass
        assign node[l+1][j] = node[l][j];
      end
    end
  end

  assign span_o = node[LEVELS];

endmodule

// File: rtl/gps_sum_form.sv
module gps_sum_form
  import gps_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]    prop_i,
  input  logic [WIDTH:0][1:0] span_i,
  output logic [WIDTH-1:0]    sum_o,
  output logic                cout_o
);

  logic [WIDTH:0] carry;

  // A resolved span decodes to its carry value.
  for (genvar k = 0; k <= WIDTH; k++) begin : g_dec
    assign carry[k] = (span_i[k] == CODE_GEN);
  end

  // span_i[i] covers slots 0..i, i.e. the carry into operand bit i (R5).
  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum_o[i] = prop_i[i] ^ carry[i];
  end

  assign cout_o = carry[WIDTH];

endmodule

// File: rtl/gps_prefix_adder.sv
module gps_prefix_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH:0][1:0] leaf_code;
  logic [WIDTH:0][1:0] span_code;
  logic [WIDTH-1:0]    prop_bit;

  gps_bit_classify #(.WIDTH(WIDTH)) u_classify (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .leaf_o (leaf_code),
    .prop_o (prop_bit)
  );

  gps_prefix_tree #(.WIDTH(WIDTH)) u_tree (
    .leaf_i (leaf_code),
    .span_o (span_code)
  );

  gps_sum_form #(.WIDTH(WIDTH)) u_sum (
    .prop_i (prop_bit),
    .span_i (span_code),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

endmodule

module gps_prefix_adder_chk
  import gps_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0]    a_i,
  input logic [WIDTH-1:0]    b_i,
  input logic                cin_i,
  input logic [WIDTH-1:0]    sum_o,
  input logic                cout_o,
  input logic [WIDTH:0][1:0] span_code
);

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    for (int k = 0; k <= WIDTH; k++) begin
      a_r4_span_resolved: assert (span_code[k] == CODE_GEN || span_code[k] == CODE_SQUASH)
        else $error("R4: span %0d unresolved", k);
    end
  end

  always_comb begin
    a_r5_sum_word: assert (sum_o == ref_total[WIDTH-1:0])
      else $error("R5: sum mismatch");
    a_r6_carry_out: assert (cout_o == ref_total[WIDTH])
      else $error("R6: carry-out mismatch");
  end

  always_comb begin
    if (&(a_i ^ b_i)) begin
      a_r3_all_pass: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}})
        else $error("R3: all-pass word wrong");
    end
    if (a_i[WIDTH-1] & b_i[WIDTH-1]) begin
      a_r1_top_generate: assert (cout_o)
        else $error("R1: top force-one lost");
    end
    if (~a_i[WIDTH-1] & ~b_i[WIDTH-1]) begin
      a_r7_top_squash: assert (!cout_o)
        else $error("R7: top force-zero ignored");
    end
  end

endmodule

bind gps_prefix_adder gps_prefix_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .cin_i     (cin_i),
  .sum_o     (sum_o),
  .cout_o    (cout_o),
  .span_code (span_code)
);

// File: tb/gps_prefix_adder_tb.sv
module gps_prefix_adder_tb;

  localparam int W         = 16;
  localparam int WDOG_LIMIT = 20000;

  typedef struct {
    logic [W:0] expv;
    string      tag;
  } item_t;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;

  item_t sb_q[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;

  gps_prefix_adder #(.WIDTH(W)) u_dut (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Driver: apply operands after a rising edge and queue the expected result.
  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input string tag);
    item_t it;
    @(posedge clk);
    a   <= av;
    b   <= bv;
    cin <= cv;
    it.expv = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: result is due in the same cycle; sample at the falling edge.
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if ({cout, sum} !== it.expv) begin
        bad++;
        $display("FAIL %s: got cout=%0b sum=%h expected cout=%0b sum=%h",
                 it.tag, cout, sum, it.expv[W], it.expv[W-1:0]);
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if ({cout, sum} !== '0) begin
      bad++;
      $display("FAIL R8 idle: got %h expected 0", {cout, sum});
    end
    rst_n = 1'b1;

    // R1: single-position classes
    for (int k = 0; k < W; k++) begin
      drive(W'(1) << k, W'(1) << k, 1'b0, "R1 force-one bit");
      drive(W'(1) << k, '0, 1'b0, "R1 pass bit");
      drive('0, '0, 1'b0, "R1 force-zero word");
    end

    // R3: all-pass word, carry-in decides everything
    drive(16'hAAAA, 16'h5555, 1'b1, "R3 all-pass cin=1");
    drive(16'hAAAA, 16'h5555, 1'b0, "R3 all-pass cin=0");
    drive(16'hFFFF, 16'h0000, 1'b1, "R3 all-pass wrap");
    drive(16'h0F0F, 16'hF0F0, 1'b0, "R3 all-pass no cin");

    // R7: long chains from a force-one at each position; squash stops them
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] above;
      above = ~((W'(1) << (k + 1)) - W'(1));
      drive((W'(1) << k) | above, W'(1) << k, 1'b0, "R7 chain to top");
      drive(above & ~(W'(1) << k), W'(0), 1'b1, "R7 squash stops chain");
    end

    // R2/R4: edge operands
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R2 all force-one");
    drive(16'hFFFF, 16'h0001, 1'b0, "R2 full ripple");
    drive(16'h8000, 16'h8000, 1'b0, "R6 top force-one");
    drive(16'h7FFF, 16'h0000, 1'b1, "R4 ripple to msb");

    // R5/R6/R8: random vectors, one per cycle
    for (int n = 0; n < 600; n++) begin
      drive(W'($urandom), W'($urandom), 1'($urandom), "R5 R6 R8 random");
    end

    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    finish_run();
  end

endmodule